// File: doc/BRIEF.md
# Carry-Completion Adder

This block adds two unsigned operands and a carry-in, and it reports when the result is ready. It does not wait out a fixed worst-case delay. Each carry position holds a two-rail code that starts as "unresolved". The code settles to a known 0 or a known 1 in one of two ways: from the operand bits at that position, or by copying the settled carry of the position below.

The model is synchronous, and one resolution step happens on each clock. A one-cycle `start` pulse captures the operands and clears every carry. The `done` output rises once no carry is unresolved, so the latency depends on the data. When `done` is high, the result and the number of steps taken are valid. They stay valid until the next `start`. A caller polls `done`, or uses `cycles` to measure how long the carry chain actually took.

Top module: `cmpl_adder`

## Requirements
- R1: After reset, `done` is 0, `cycles` is 0 and `sum` is 0.
- R2: A cycle with `start` high captures `x`, `y` and `cin`, and sets every carry position to unresolved. This happens even while an earlier addition is still resolving, and the new operands fully replace the old ones.
- R3: Each carry uses a two-rail code: 00 means unresolved, 01 means known 1 and 10 means known 0. The code 11 never appears. A carry that is known keeps its value until the next `start`.
- R4: On the first step after `start`, the carry out of position i becomes known 1 where x_i and y_i are both 1, and known 0 where both are 0. The carry into position 0 becomes the captured `cin` on that same first step.
- R5: Where exactly one of x_i and y_i is 1, the carry out of position i takes the value of the carry into position i on the step after that lower carry becomes known.
- R6: `done` is high exactly when every carry position is known and an addition has been started. It stays high, with `sum`, `cout` and `cycles` unchanged, until the next `start`.
- R7: When `done` is high, `{cout, sum}` equals x + y + cin.
- R8: When `done` rises, `cycles` equals the length of the longest run of adjacent positions where x_i differs from y_i, plus one. The worst case is WIDTH+1.
- R9: `done` is low on the cycle after `start`, and `cycles` reads 0 on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures operands and begins a new addition |
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits, valid while `done` is high |
| cout | output | 1 | Carry out of the top bit, valid while `done` is high |
| done | output | 1 | All carries are resolved |
| cycles | output | CNT_W | Resolution steps taken since `start` |

## Verification
A carry cell that resolves too early or too late changes `cycles` and moves the rising edge of `done` by at least one clock. The bench compares both against the longest differing run it computes itself, on every operand pair. A cell that settles to the wrong value shows up as a wrong `sum` or `cout` bit on the first cycle `done` is high. A known carry that drifts afterwards shows up in the hold check a few cycles later. Because the sweep is exhaustive over a six-bit configuration, every propagate-run length and run position is observed at the ports.

// File: rtl/cmpl_adder_pkg.sv
package cmpl_adder_pkg;

  typedef logic [1:0] rail_t;

  localparam rail_t RAIL_UNK  = 2'b00;
  localparam rail_t RAIL_ONE  = 2'b01;
  localparam rail_t RAIL_ZERO = 2'b10;

  function automatic logic rail_known(input rail_t r);
    return r[0] | r[1];
  endfunction

  // One resolution step for the carry above a bit position.
  function automatic rail_t rail_next(input rail_t cur, input rail_t lower,
                                      input logic gen, input logic kill,
                                      input logic prop);
    rail_t nxt;
    nxt = cur;
    if (!rail_known(cur)) begin
      if (gen)                            nxt = RAIL_ONE;
      else if (kill)                      nxt = RAIL_ZERO;
      else if (prop && rail_known(lower)) nxt = lower;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/cmpl_carry_cell.sv
module cmpl_carry_cell
  import cmpl_adder_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  logic  step,
  input  logic  xb,
  input  logic  yb,
  input  rail_t lo_rail,
  output rail_t rail_q
);

  logic  gen_w, kill_w, prop_w;
  rail_t rail_d;

  assign gen_w  = xb & yb;
  assign kill_w = ~xb & ~yb;
  assign prop_w = xb ^ yb;

  always_comb rail_d = rail_next(rail_q, lo_rail, gen_w, kill_w, prop_w);

  always_ff @(posedge clk) begin
    if (rst)       rail_q <= RAIL_UNK;
    else if (load) rail_q <= RAIL_UNK;
    else if (step) rail_q <= rail_d;
  end

  AST_RAIL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rail_q != 2'b11); // R3
  AST_RAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!load && rail_known(rail_q)) |=> $stable(rail_q)); // R3
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    load |=> (rail_q == RAIL_UNK)); // R2
  AST_GEN_FIRST: assert property (@(posedge clk) disable iff (rst)
    (step && !load && gen_w) |=> (rail_q == RAIL_ONE)); // R4
  AST_KILL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (step && !load && kill_w) |=> (rail_q == RAIL_ZERO)); // R4
  AST_PROP_COPY: assert property (@(posedge clk) disable iff (rst)
    (step && !load && prop_w && rail_known(lo_rail) && !rail_known(rail_q))
      |=> (rail_q == $past(lo_rail))); // R5

endmodule

// File: rtl/cmpl_detect.sv
module cmpl_detect
  import cmpl_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH:0][1:0] rails,
  input  logic [WIDTH-1:0]    xq,
  input  logic [WIDTH-1:0]    yq,
  output logic                all_known,
  output logic [WIDTH-1:0]    sum,
  output logic                cout
);

  logic [WIDTH:0] known_vec;

  for (genvar j = 0; j <= WIDTH; j++) begin : g_known
    assign known_vec[j] = rail_known(rails[j]);
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sum[i] = xq[i] ^ yq[i] ^ rails[i][0];
  end

  assign all_known = &known_vec;
  assign cout      = rails[WIDTH][0];

endmodule

// File: rtl/cmpl_ctrl.sv
module cmpl_ctrl #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             all_known,
  output logic             load,
  output logic             step,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);

  typedef enum logic {PH_IDLE, PH_RUN} phase_t;
  phase_t phase_q;

  assign load = start;
  assign step = (phase_q == PH_RUN) && !all_known;
  assign done = (phase_q == PH_RUN) && all_known;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt     <= '0;
    end else if (start) begin
      phase_q <= PH_RUN;
      cnt     <= '0;
    end else if (step) begin
      cnt     <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WIDTH + 1)); // R8
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(cnt))); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && cnt == '0)); // R9

endmodule

// File: rtl/cmpl_adder.sv
module cmpl_adder
  import cmpl_adder_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             done,
  output logic [CNT_W-1:0] cycles
);

  logic [WIDTH-1:0]   x_q, y_q;
  logic               cin_q;
  logic [WIDTH:0]     bx_ext, by_ext;
  logic [WIDTH:0][1:0] rails;
  logic               load_w, step_w, all_known_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_q   <= '0;
      cin_q <= 1'b0;
    end else if (start) begin
      x_q   <= x;
      y_q   <= y;
      cin_q <= cin;
    end
  end

  // Position 0 sees the carry-in as a generate/kill pair.
  assign bx_ext = {x_q, cin_q};
  assign by_ext = {y_q, cin_q};

  for (genvar j = 0; j <= WIDTH; j++) begin : g_cell
    rail_t lo_w;
    if (j == 0) begin : g_base
      assign lo_w = RAIL_UNK;
    end else begin : g_chain
      assign lo_w = rails[j-1];
    end
    cmpl_carry_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .load    (load_w),
      .step    (step_w),
      .xb      (bx_ext[j]),
      .yb      (by_ext[j]),
      .lo_rail (lo_w),
      .rail_q  (rails[j])
    );
  end

  cmpl_detect #(.WIDTH(WIDTH)) u_detect (
    .rails     (rails),
    .xq        (x_q),
    .yq        (y_q),
    .all_known (all_known_w),
    .sum       (sum),
    .cout      (cout)
  );

  cmpl_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .all_known (all_known_w),
    .load      (load_w),
    .step      (step_w),
    .done      (done),
    .cnt       (cycles)
  );

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |-> ({cout, sum} == ({1'b0, x_q} + {1'b0, y_q} + {{WIDTH{1'b0}}, cin_q}))); // R7

endmodule

// File: tb/cmpl_adder_tb_top.sv
module cmpl_adder_tb_top;
  localparam int W  = 6;
  localparam int CW = $clog2(W + 2);

  logic          clk = 1'b0;
  logic          rst, start, cin;
  logic [W-1:0]  x, y, sum;
  logic          cout, done;
  logic [CW-1:0] cycles;
  int            n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  cmpl_adder #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .x(x), .y(y), .cin(cin),
    .sum(sum), .cout(cout), .done(done), .cycles(cycles)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int longest_run(input int a, input int b);
    int best = 0, cur = 0;
    for (int i = 0; i < W; i++) begin
      if (((a >> i) & 1) != ((b >> i) & 1)) begin
        cur++;
        if (cur > best) best = cur;
      end else cur = 0;
    end
    return best;
  endfunction

  task automatic launch(input int a, input int b, input int c);
    @(negedge clk);
    x = W'(a); y = W'(b); cin = c[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Starts one addition and checks result, latency and count.
  task automatic run_one(input int a, input int b, input int c);
    int exp_lat, steps, total;
    exp_lat = longest_run(a, b) + 1;
    total   = a + b + c;
    launch(a, b, c);
    check("R9 done low after start", int'(done), 0);
    steps = 0;
    while (!done && steps < W + 3) begin
      @(negedge clk);
      steps++;
    end
    check("R8 steps until done", steps, exp_lat);
    check("R8 cycles output", int'(cycles), exp_lat);
    check("R7 sum and carry-out", int'({cout, sum}), total);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; x = '1; y = '1; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 cycles after reset", int'(cycles), 0);
    check("R1 sum after reset", int'(sum), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done stays low without start", int'(done), 0);

    // R4, R5: sweep every operand pair and carry-in
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        for (int c = 0; c < 2; c++)
          run_one(a, b, c);

    // R3, R6: result holds after done until the next start
    run_one(6'h15, 6'h2a, 1);
    repeat (4) @(negedge clk);
    check("R6 done holds", int'(done), 1);
    check("R6 cycles hold", int'(cycles), W + 1);
    check("R3 known carries hold, sum stable", int'({cout, sum}), 6'h15 + 6'h2a + 1);

    // R2: restart in the middle of a long propagation
    launch(0, (1 << W) - 1, 1);
    @(negedge clk);
    check("R2 busy before restart", int'(done), 0);
    run_one(1, 1, 0);
    check("R2 restart result", int'(sum), 2);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule